// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block is the hazard-resolution logic of a five-stage integer pipeline whose stages are fetch, decode, execute, memory and write-back. Source registers are read in decode and the register file is written only in write-back. The unit looks at the register specifiers and control flags held in the four pipeline registers. It compares the destinations of the two oldest instructions in flight against the sources of the younger ones.

From that comparison it produces several control outputs. There is one select for each of the two ALU operand multiplexers. There is a select for the store-data input of the data memory. There are two bypass flags for the decode-stage register reads. Finally there is a stall with a matching bubble request for a load followed by a dependent instruction.

A store may take its data from the load just ahead of it without waiting. The loaded word is routed straight to the memory write port. All outputs are pure combinational functions of the present stage fields. The surrounding pipeline samples them in the same cycle.

Top module: `hazard_unit`

## Requirements
- R1: An ALU operand select is 2'b10 (take the memory-stage result) when the memory-stage instruction writes a register, its destination is nonzero, and that destination equals the operand's source in execute.
- R2: An ALU operand select is 2'b01 (take the write-back value) when the memory-stage instruction does not supply that operand under R1, and the write-back instruction writes a nonzero destination equal to the source.
- R3: When both the memory-stage and the write-back destinations match the same source, the select is 2'b10, because the memory-stage value is the newest.
- R4: An operand select is 2'b00 (register-file data) whenever neither R1 nor R2 applies. This includes every case where the matching producer has its write flag clear or targets register 0.
- R5: The code 2'b11 never appears on either operand select.
- R6: The store-data select is 1 (use the loaded word from write-back) exactly when the memory-stage instruction is a store, the write-back instruction is a load with its write flag set, and the load's nonzero destination equals the store's data register.
- R7: Each decode bypass flag is 1 exactly when that source is used, and the write-back instruction writes a nonzero destination equal to it.
- R8: The stall output is 1 when the execute-stage instruction is a load with its write flag set and a nonzero destination, and that destination equals a decode source that the decode instruction uses as an ALU operand or as an address base.
- R9: A decode-stage store whose only dependence on an execute-stage load is its data register (the second source, flagged as store data) does not stall.
- R10: The bubble output equals the stall output in every cycle: fetch and decode are held in the same cycle that a no-op is placed into execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | 5 | First source register of the decode instruction |
| id_rt | input | 5 | Second source register of the decode instruction |
| id_rs_used | input | 1 | Decode instruction reads its first source |
| id_rt_used | input | 1 | Decode instruction reads its second source |
| id_rt_is_sdata | input | 1 | Second source of the decode instruction is store data only |
| ex_rs | input | 5 | First source of the execute instruction |
| ex_rt | input | 5 | Second source of the execute instruction |
| ex_dst | input | 5 | Destination of the execute instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_dst | input | 5 | Destination of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_rt | input | 5 | Store data register of the memory-stage instruction |
| wb_dst | input | 5 | Destination of the write-back instruction |
| wb_wr | input | 1 | Write-back instruction writes a register |
| wb_is_load | input | 1 | Write-back instruction is a load |
| fwd_a | output | 2 | First ALU operand select |
| fwd_b | output | 2 | Second ALU operand select |
| sdata_sel | output | 1 | Store-data select, 1 for the loaded word |
| id_byp_rs | output | 1 | Bypass the write-back value into the first decode read |
| id_byp_rt | output | 1 | Bypass the write-back value into the second decode read |
| stall | output | 1 | Hold program counter and fetch/decode register |
| bubble | output | 1 | Place a no-op into the execute stage |

## Verification
Every result of this unit is due in the same cycle as the stage fields that cause it, with no register anywhere on the path. The bench therefore applies each vector on the falling clock edge and compares all outputs a short settle time later, before the next rising edge. Register numbers are swept over a small set that includes register 0 and repeated values, and all control flags are swept through every combination. This covers the priority, zero-register and store-data corner cases alongside the ordinary matches.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  localparam int unsigned REG_AW = 5;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } opnd_sel_e;

  // A producer is eligible to bypass when it writes and its target is not r0.
  function automatic logic producer_hits(input logic wr,
                                         input logic [REG_AW-1:0] dst,
                                         input logic [REG_AW-1:0] src);
    return wr && (dst != '0) && (dst == src);
  endfunction

endpackage

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
  import hazard_pkg::*;
(
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr,
  output logic [1:0]        sel
);

  logic hit_mem;
  logic hit_wb;

  always_comb begin
    hit_mem = producer_hits(mem_wr, mem_dst, src);
    hit_wb  = producer_hits(wb_wr, wb_dst, src);
  end

  // Newest producer first.
  always_comb begin
    if (hit_mem)     sel = SEL_MEM;
    else if (hit_wb) sel = SEL_WB;
    else             sel = SEL_RF;
  end

endmodule

// File: rtl/hz_decode_bypass.sv
module hz_decode_bypass
  import hazard_pkg::*;
(
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_rs_used,
  input  logic              id_rt_used,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr,
  output logic              byp_rs,
  output logic              byp_rt
);

  always_comb begin
    byp_rs = id_rs_used && producer_hits(wb_wr, wb_dst, id_rs);
    byp_rt = id_rt_used && producer_hits(wb_wr, wb_dst, id_rt);
  end

endmodule

// File: rtl/hz_store_fwd.sv
module hz_store_fwd
  import hazard_pkg::*;
(
  input  logic              mem_is_store,
  input  logic [REG_AW-1:0] mem_rt,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr,
  input  logic              wb_is_load,
  output logic              sdata_sel
);

  always_comb begin
    sdata_sel = mem_is_store && wb_is_load && producer_hits(wb_wr, wb_dst, mem_rt);
  end

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hazard_pkg::*;
(
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_rs_used,
  input  logic              id_rt_used,
  input  logic              id_rt_is_sdata,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wr,
  input  logic              ex_is_load,
  output logic              stall,
  output logic              bubble
);

  logic need_rs;
  logic need_rt;
  logic load_use;

  always_comb begin
    // Store data is picked up later on the memory-to-memory path.
    need_rs  = id_rs_used;
    need_rt  = id_rt_used && !id_rt_is_sdata;
    load_use = ex_is_load &&
               ((need_rs && producer_hits(ex_wr, ex_dst, id_rs)) ||
                (need_rt && producer_hits(ex_wr, ex_dst, id_rt)));
    stall    = load_use;
    bubble   = load_use;
  end

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
(
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_rs_used,
  input  logic              id_rt_used,
  input  logic              id_rt_is_sdata,
  input  logic [REG_AW-1:0] ex_rs,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wr,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr,
  input  logic              mem_is_store,
  input  logic [REG_AW-1:0] mem_rt,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr,
  input  logic              wb_is_load,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              sdata_sel,
  output logic              id_byp_rs,
  output logic              id_byp_rt,
  output logic              stall,
  output logic              bubble
);

  localparam int unsigned N_OPND = 2;

  logic [REG_AW-1:0] opnd_src [N_OPND];
  logic [1:0]        opnd_sel [N_OPND];

  assign opnd_src[0] = ex_rs;
  assign opnd_src[1] = ex_rt;

  generate
    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
      hz_operand_fwd u_fwd (
        .src     (opnd_src[i]),
        .mem_dst (mem_dst),
        .mem_wr  (mem_wr),
        .wb_dst  (wb_dst),
        .wb_wr   (wb_wr),
        .sel     (opnd_sel[i])
      );
    end
  endgenerate

  assign fwd_a = opnd_sel[0];
  assign fwd_b = opnd_sel[1];

  hz_store_fwd u_sfwd (
    .mem_is_store (mem_is_store),
    .mem_rt       (mem_rt),
    .wb_dst       (wb_dst),
    .wb_wr        (wb_wr),
    .wb_is_load   (wb_is_load),
    .sdata_sel    (sdata_sel)
  );

  hz_decode_bypass u_idb (
    .id_rs      (id_rs),
    .id_rt      (id_rt),
    .id_rs_used (id_rs_used),
    .id_rt_used (id_rt_used),
    .wb_dst     (wb_dst),
    .wb_wr      (wb_wr),
    .byp_rs     (id_byp_rs),
    .byp_rt     (id_byp_rt)
  );

  hz_interlock u_ilk (
    .id_rs          (id_rs),
    .id_rt          (id_rt),
    .id_rs_used     (id_rs_used),
    .id_rt_used     (id_rt_used),
    .id_rt_is_sdata (id_rt_is_sdata),
    .ex_dst         (ex_dst),
    .ex_wr          (ex_wr),
    .ex_is_load     (ex_is_load),
    .stall          (stall),
    .bubble         (bubble)
  );

endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk
  import hazard_pkg::*;
(
  input logic [REG_AW-1:0] id_rs,
  input logic              id_rs_used,
  input logic              id_rt_used,
  input logic              id_rt_is_sdata,
  input logic [REG_AW-1:0] ex_dst,
  input logic              ex_is_load,
  input logic [REG_AW-1:0] mem_dst,
  input logic [REG_AW-1:0] wb_dst,
  input logic              mem_is_store,
  input logic              wb_is_load,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b,
  input logic              sdata_sel,
  input logic              id_byp_rs,
  input logic              stall,
  input logic              bubble
);

  logic known;
  assign known = !$isunknown({id_rs, id_rs_used, id_rt_used, id_rt_is_sdata, ex_dst,
                              ex_is_load, mem_dst, wb_dst, mem_is_store, wb_is_load,
                              fwd_a, fwd_b, sdata_sel, id_byp_rs, stall, bubble});

  always_comb begin
    if (known) begin
      a_r5_no_unused_code: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
      a_r4_zero_targets_use_rf: assert (!(mem_dst == '0 && wb_dst == '0) ||
                                        (fwd_a == SEL_RF && fwd_b == SEL_RF));
      a_r6_sdata_needs_store_load: assert (!sdata_sel || (mem_is_store && wb_is_load));
      a_r7_no_bypass_from_r0: assert (!(id_byp_rs && id_rs == '0));
      a_r8_stall_needs_load: assert (!stall || (ex_is_load && ex_dst != '0));
      a_r9_store_data_no_stall: assert (!(!id_rs_used && id_rt_used && id_rt_is_sdata) || !stall);
      a_r10_bubble_with_stall: assert (bubble == stall);
    end
  end

endmodule

bind hazard_unit hazard_unit_chk u_chk (
  .id_rs          (id_rs),
  .id_rs_used     (id_rs_used),
  .id_rt_used     (id_rt_used),
  .id_rt_is_sdata (id_rt_is_sdata),
  .ex_dst         (ex_dst),
  .ex_is_load     (ex_is_load),
  .mem_dst        (mem_dst),
  .wb_dst         (wb_dst),
  .mem_is_store   (mem_is_store),
  .wb_is_load     (wb_is_load),
  .fwd_a          (fwd_a),
  .fwd_b          (fwd_b),
  .sdata_sel      (sdata_sel),
  .id_byp_rs      (id_byp_rs),
  .stall          (stall),
  .bubble         (bubble)
);

// File: tb/hazard_unit_test.sv
`timescale 1ns/1ps
module hazard_unit_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, mem_rt, wb_dst;
  logic id_rs_used, id_rt_used, id_rt_is_sdata, ex_wr, ex_is_load;
  logic mem_wr, mem_is_store, wb_wr, wb_is_load;
  logic [1:0] fwd_a, fwd_b;
  logic sdata_sel, id_byp_rs, id_byp_rt, stall, bubble;

  hazard_unit uut (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_sel(input int s, input int md, input bit mw,
                                 input int wd, input bit ww);
    bit m, w;
    m = mw && md != 0 && md == s;
    w = ww && wd != 0 && wd == s;
    return m ? 2 : (w ? 1 : 0);
  endfunction

  task automatic idle();
    {id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, mem_rt, wb_dst} = '0;
    {id_rs_used, id_rt_used, id_rt_is_sdata, ex_wr, ex_is_load} = '0;
    {mem_wr, mem_is_store, wb_wr, wb_is_load} = '0;
  endtask

  initial begin
    idle();
    @(negedge clk); #2;
    check("R4 idle fwd_a", fwd_a, 0);
    check("R4 idle fwd_b", fwd_b, 0);
    check("R8 idle stall", stall, 0);
    check("R6 idle sdata", sdata_sel, 0);

    // Operand selects: R1 R2 R3 R4 R5
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int md = 0; md < 4; md++)
          for (int wd = 0; wd < 4; wd++)
            for (int f = 0; f < 4; f++) begin
              @(negedge clk);
              idle();
              ex_rs = a[4:0]; ex_rt = b[4:0]; mem_dst = md[4:0]; wb_dst = wd[4:0];
              mem_wr = f[0]; wb_wr = f[1];
              #2;
              check("R1/R2/R3/R4 fwd_a", fwd_a, exp_sel(a, md, f[0], wd, f[1]));
              check("R1/R2/R3/R4 fwd_b", fwd_b, exp_sel(b, md, f[0], wd, f[1]));
              if (md == a && wd == a && a != 0 && f == 3)
                check("R3 priority fwd_a", fwd_a, 2);
              check("R5 no code 3", int'(fwd_a == 2'b11 || fwd_b == 2'b11), 0);
            end

    // Store data path: R6
    for (int r = 0; r < 4; r++)
      for (int wd = 0; wd < 4; wd++)
        for (int f = 0; f < 8; f++) begin
          @(negedge clk);
          idle();
          mem_rt = r[4:0]; wb_dst = wd[4:0];
          mem_is_store = f[0]; wb_is_load = f[1]; wb_wr = f[2];
          #2;
          check("R6 sdata_sel", sdata_sel,
                int'(f == 7 && wd != 0 && wd == r));
        end

    // Decode bypass and interlock: R7 R8 R9 R10
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++)
        for (int ed = 0; ed < 4; ed++)
          for (int wd = 0; wd < 4; wd++)
            for (int f = 0; f < 64; f++) begin
              bit need_s, need_t, exp_st;
              @(negedge clk);
              idle();
              id_rs = s[4:0]; id_rt = t[4:0]; ex_dst = ed[4:0]; wb_dst = wd[4:0];
              id_rs_used = f[0]; id_rt_used = f[1]; id_rt_is_sdata = f[2];
              ex_is_load = f[3]; ex_wr = f[4]; wb_wr = f[5];
              #2;
              check("R7 id_byp_rs", id_byp_rs, int'(f[0] && f[5] && wd != 0 && wd == s));
              check("R7 id_byp_rt", id_byp_rt, int'(f[1] && f[5] && wd != 0 && wd == t));
              need_s = f[0] && ed == s;
              need_t = f[1] && !f[2] && ed == t;
              exp_st = f[3] && f[4] && ed != 0 && (need_s || need_t);
              check("R8 stall", stall, int'(exp_st));
              if (!f[0] && f[1] && f[2]) check("R9 store data no stall", stall, 0);
              check("R10 bubble", bubble, int'(exp_st));
            end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule